// File: doc/BRIEF.md
# ALU Status and Control Flag Register

This block holds the 16-bit condition word that sits next to an 8/16-bit ALU. Each cycle the ALU hands over its two operands, its result, the carry or borrow out of the top bit of the active width, and an operation class. From these the block works out six status flags: carry, parity, auxiliary carry, zero, sign and overflow. A per-operation update mask then chooses which of those flags are actually written. Three control flags (direction, interrupt enable, trap) are kept in the same word. Arithmetic never touches them; only explicit writes change them.

Software-visible control is through two paths. A single-flag write sets or clears the flag at a chosen bit position. A full-word load replaces every flag at once. The register value is always on `flags_o`, which serves as the store path. Bits that carry no flag read as a fixed pattern and ignore all writes. Every change shows on `flags_o` one clock after the request.

Top module: `alu_flag_reg`

## Requirements
- R1: After reset `flags_o` reads 16'hF002: all nine flags are 0, bits 1 and 12 to 15 read 1, and bits 3 and 5 read 0.
- R2: The non-flag bits (1, 3, 5, 12 to 15) always read the fixed pattern of R1, whatever is loaded or written.
- R3: For op_class 2'b00 (add) or 2'b01 (subtract), carry (bit 0) takes `alu_carry`. This input is the carry out of, or borrow into, the top bit of the active width.
- R4: For add or subtract, auxiliary carry (bit 4) is set when there is a carry or borrow between bit 3 and bit 4, that is, when bit 4 of opa XOR opb XOR result is 1.
- R5: Overflow (bit 11) is set on signed overflow in the active width. For add this means the operand sign bits are equal and the result sign differs from them. For subtract it means the operand sign bits differ and the result sign differs from opa.
- R6: Sign (bit 7) is the top bit of the active width: bit 15 when `word_op`=1 and bit 7 when `word_op`=0. Zero (bit 6) is set when the result bits of the active width are all 0.
- R7: Parity (bit 2) is 1 when `result[7:0]` holds an even number of ones, for both byte and word operations.
- R8: With `upd_valid`=1, only the status flags whose `upd_mask` bit is 1 change. The mask bit order is [0]=carry, [1]=parity, [2]=aux, [3]=zero, [4]=sign, [5]=overflow. A zero mask leaves the register unchanged.
- R9: For op_class 2'b10 or 2'b11 (logic), carry and overflow are written as 0 (when masked in), and auxiliary carry keeps its value.
- R10: Trap (bit 8), interrupt enable (bit 9) and direction (bit 10) change only through `load` or `bit_wr`.
- R11: `bit_wr` writes `bit_val` into the flag at position `bit_sel`. A `bit_sel` that names a non-flag bit has no effect.
- R12: `load` writes the flag bits of `load_data` into the register. Priority is load, then bit_wr, then upd_valid. Each write shows on `flags_o` after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Apply the ALU result this cycle |
| op_class | input | 2 | 00 add, 01 subtract, 10/11 logic |
| word_op | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opa | input | 16 | First ALU operand |
| opb | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| alu_carry | input | 1 | Carry/borrow out of the top bit of the active width |
| upd_mask | input | 6 | Per-status-flag write enable |
| bit_wr | input | 1 | Single-flag write strobe |
| bit_sel | input | 4 | Bit position for the single-flag write |
| bit_val | input | 1 | Value for the single-flag write |
| load | input | 1 | Full-word load strobe |
| load_data | input | 16 | Word to load |
| flags_o | output | 16 | Current register value |

## Verification
The register feeds its own outputs straight out, so any wrong internal bit appears on `flags_o` in the cycle right after the edge that stored it. Two kinds of fault are hidden by their effect: flags that an update should not have touched, and a masked write that leaked into a held flag. These show only as a bit that differs from a reference model which tracks held flags across operations. The bench therefore runs directed corner cases followed by a long random stream of add, subtract and logic operations with random masks. After every cycle it compares the whole word, so a stale or corrupted bit is caught one cycle after it appears.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
    localparam int REG_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int NUM_STAT = 6;
    localparam int SEL_W    = $clog2(REG_W);

    // status flag indices into the update mask
    localparam int ST_CF = 0;
    localparam int ST_PF = 1;
    localparam int ST_AF = 2;
    localparam int ST_ZF = 3;
    localparam int ST_SF = 4;
    localparam int ST_OF = 5;

    // bit positions in the register
    localparam int POS_CF  = 0;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_TRP = 8;
    localparam int POS_IEN = 9;
    localparam int POS_DIR = 10;
    localparam int POS_OF  = 11;

    localparam logic [REG_W-1:0] FLAG_MASK  = 16'h0FD5;
    localparam logic [REG_W-1:0] RSVD_FIXED = 16'hF002;
    localparam logic [REG_W-1:0] CTRL_MASK  = 16'h0700;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_LOGIC = 2'b10,
        OPC_LOGX  = 2'b11
    } op_class_e;

    typedef struct packed {
        logic [REG_W-1:0] word;
    } freg_t;

    function automatic int stat_pos(input int idx);
        case (idx)
            ST_CF:   return POS_CF;
            ST_PF:   return POS_PF;
            ST_AF:   return POS_AF;
            ST_ZF:   return POS_ZF;
            ST_SF:   return POS_SF;
            default: return POS_OF;
        endcase
    endfunction
endpackage

// File: rtl/flag_parity.sv
module flag_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    output logic         even
);
    logic [W:0] acc;
    assign acc[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign acc[i+1] = acc[i] ^ bits[i];
    end
    assign even = ~acc[W];
endmodule

// File: rtl/flag_gen.sv
module flag_gen
    import flagreg_pkg::*;
(
    input  logic [1:0]          op_class,
    input  logic                word_op,
    input  logic [REG_W-1:0]    opa,
    input  logic [REG_W-1:0]    opb,
    input  logic [REG_W-1:0]    result,
    input  logic                alu_carry,
    input  logic [NUM_STAT-1:0] upd_mask,
    output logic [NUM_STAT-1:0] stat_val,
    output logic [NUM_STAT-1:0] stat_we
);
    logic is_add, is_sub, is_arith;
    logic a_top, b_top, r_top;
    logic par_even, res_zero;
    logic [REG_W-1:0] xsum;

    flag_parity #(.W(BYTE_W)) u_par (
        .bits (result[BYTE_W-1:0]),
        .even (par_even)
    );

    always_comb begin
        is_add   = (op_class == OPC_ADD);
        is_sub   = (op_class == OPC_SUB);
        is_arith = is_add | is_sub;
        a_top    = word_op ? opa[REG_W-1]    : opa[BYTE_W-1];
        b_top    = word_op ? opb[REG_W-1]    : opb[BYTE_W-1];
        r_top    = word_op ? result[REG_W-1] : result[BYTE_W-1];
        res_zero = word_op ? (result == '0) : (result[BYTE_W-1:0] == '0);
        xsum     = opa ^ opb ^ result;

        stat_val        = '0;
        stat_val[ST_CF] = is_arith & alu_carry;
        stat_val[ST_PF] = par_even;
        stat_val[ST_AF] = xsum[NIB_W];
        stat_val[ST_ZF] = res_zero;
        stat_val[ST_SF] = r_top;
        stat_val[ST_OF] = (is_add & (a_top == b_top) & (r_top != a_top))
                        | (is_sub & (a_top != b_top) & (r_top != a_top));

        stat_we        = upd_mask;
        stat_we[ST_AF] = upd_mask[ST_AF] & is_arith;
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import flagreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_valid,
    input  logic [1:0]          op_class,
    input  logic                word_op,
    input  logic [REG_W-1:0]    opa,
    input  logic [REG_W-1:0]    opb,
    input  logic [REG_W-1:0]    result,
    input  logic                alu_carry,
    input  logic [NUM_STAT-1:0] upd_mask,
    input  logic                bit_wr,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic                bit_val,
    input  logic                load,
    input  logic [REG_W-1:0]    load_data,
    output logic [REG_W-1:0]    flags_o
);
    freg_t st_d, st_q;
    logic [NUM_STAT-1:0] stat_val, stat_we;

    flag_gen u_gen (
        .op_class  (op_class),
        .word_op   (word_op),
        .opa       (opa),
        .opb       (opb),
        .result    (result),
        .alu_carry (alu_carry),
        .upd_mask  (upd_mask),
        .stat_val  (stat_val),
        .stat_we   (stat_we)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.word = (load_data & FLAG_MASK) | RSVD_FIXED;
        end else if (bit_wr) begin
            if (FLAG_MASK[bit_sel]) begin
                st_d.word[bit_sel] = bit_val;
            end
        end else if (upd_valid) begin
            for (int i = 0; i < NUM_STAT; i++) begin
                if (stat_we[i]) begin
                    st_d.word[stat_pos(i)] = stat_val[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= RSVD_FIXED;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.word;
endmodule

// File: rtl/alu_flag_reg_chk.sv
module alu_flag_reg_chk
    import flagreg_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                upd_valid,
    input logic [1:0]          op_class,
    input logic [NUM_STAT-1:0] upd_mask,
    input logic                bit_wr,
    input logic [SEL_W-1:0]    bit_sel,
    input logic                bit_val,
    input logic                load,
    input logic [REG_W-1:0]    load_data,
    input logic [REG_W-1:0]    flags_o
);
    logic upd_only;
    assign upd_only = upd_valid & ~load & ~bit_wr;

    assert_rsvd_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~FLAG_MASK) == RSVD_FIXED);

    assert_load_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> flags_o == (($past(load_data) & FLAG_MASK) | RSVD_FIXED));

    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !bit_wr) |=> $stable(flags_o & CTRL_MASK));

    assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && op_class[1] && upd_mask[ST_CF] && upd_mask[ST_OF])
        |=> (!flags_o[POS_CF] && !flags_o[POS_OF] && $stable(flags_o[POS_AF])));

    assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && upd_mask == '0) |=> $stable(flags_o));

    assert_zero_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_only && upd_mask[ST_ZF] && upd_mask[ST_SF])
        |=> !(flags_o[POS_ZF] && flags_o[POS_SF]));

    assert_bit_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr && !load && FLAG_MASK[bit_sel])
        |=> flags_o[$past(bit_sel)] == $past(bit_val));
endmodule

bind alu_flag_reg alu_flag_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .op_class  (op_class),
    .upd_mask  (upd_mask),
    .bit_wr    (bit_wr),
    .bit_sel   (bit_sel),
    .bit_val   (bit_val),
    .load      (load),
    .load_data (load_data),
    .flags_o   (flags_o)
);

// File: tb/tb_alu_flag_reg.sv
`timescale 1ns/1ps
module tb_alu_flag_reg;
    import flagreg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        upd_valid;
    logic [1:0]  op_class;
    logic        word_op;
    logic [15:0] opa, opb, result;
    logic        alu_carry;
    logic [5:0]  upd_mask;
    logic        bit_wr;
    logic [3:0]  bit_sel;
    logic        bit_val;
    logic        load;
    logic [15:0] load_data;
    logic [15:0] flags_o;

    always #10 clk = ~clk;

    alu_flag_reg dut (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
        .word_op(word_op), .opa(opa), .opb(opb), .result(result),
        .alu_carry(alu_carry), .upd_mask(upd_mask), .bit_wr(bit_wr),
        .bit_sel(bit_sel), .bit_val(bit_val), .load(load),
        .load_data(load_data), .flags_o(flags_o)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] model = 16'hF002;

    localparam logic [15:0] M_FLAGS = 16'h0FD5;
    localparam logic [15:0] M_RSVD  = 16'hF002;

    function automatic logic [15:0] model_upd(
        input logic [15:0] cur, input logic [1:0] cls, input logic wop,
        input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
        input logic c, input logic [5:0] m);
        logic [15:0] n;
        logic at, bt, rt, arith, ov, par, zf;
        n  = cur;
        at = wop ? a[15] : a[7];
        bt = wop ? b[15] : b[7];
        rt = wop ? r[15] : r[7];
        arith = (cls == 2'b00) || (cls == 2'b01);
        if (cls == 2'b00)      ov = (at == bt) && (rt != at);
        else if (cls == 2'b01) ov = (at != bt) && (rt != at);
        else                   ov = 1'b0;
        par = ($countones(r[7:0]) % 2) == 0;
        zf  = wop ? (r == 16'h0) : (r[7:0] == 8'h0);
        if (m[0]) n[0]  = arith ? c : 1'b0;
        if (m[1]) n[2]  = par;
        if (m[2] && arith) n[4] = a[4] ^ b[4] ^ r[4];
        if (m[3]) n[6]  = zf;
        if (m[4]) n[7]  = rt;
        if (m[5]) n[11] = ov;
        return n;
    endfunction

    task automatic drive(
        input logic ld, input logic [15:0] ldd,
        input logic bw, input logic [3:0] sel, input logic bv,
        input logic up, input logic [1:0] cls, input logic wop,
        input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
        input logic c, input logic [5:0] m, input string tag);
        item_t it;
        @(negedge clk);
        load = ld; load_data = ldd;
        bit_wr = bw; bit_sel = sel; bit_val = bv;
        upd_valid = up; op_class = cls; word_op = wop;
        opa = a; opb = b; result = r; alu_carry = c; upd_mask = m;
        if (ld)       model = (ldd & M_FLAGS) | M_RSVD;
        else if (bw)  begin if (M_FLAGS[sel]) model[sel] = bv; end
        else if (up)  model = model_upd(model, cls, wop, a, b, r, c, m);
        it.exp = model;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle(input string tag);
        drive(0, 16'h0, 0, 4'h0, 0, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, tag);
    endtask

    // arithmetic op: bench computes result and carry itself
    task automatic alu_op(input logic [1:0] cls, input logic wop,
                          input logic [15:0] a, input logic [15:0] b,
                          input logic [5:0] m, input string tag);
        logic [16:0] w;
        logic [8:0]  s;
        logic [15:0] r;
        logic        c;
        if (cls == 2'b00) begin
            if (wop) begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16]; end
            else begin s = {1'b0, a[7:0]} + {1'b0, b[7:0]}; r = {a[15:8], s[7:0]}; c = s[8]; end
        end else if (cls == 2'b01) begin
            if (wop) begin w = {1'b0, a} - {1'b0, b}; r = w[15:0]; c = w[16]; end
            else begin s = {1'b0, a[7:0]} - {1'b0, b[7:0]}; r = {a[15:8], s[7:0]}; c = s[8]; end
        end else begin
            r = a & b; c = 1'b0;
        end
        drive(0, 16'h0, 0, 4'h0, 0, 1, cls, wop, a, b, r, c, m, tag);
    endtask

    // monitor: compare one item per clock, after the register has updated
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() != 0) begin
                it = sbq.pop_front();
                checks++;
                if (flags_o !== it.exp) begin
                    errors++;
                    $display("FAIL %s: flags_o=%h expected %h", it.tag, flags_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: R12 run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        upd_valid = 0; op_class = 0; word_op = 0; opa = 0; opb = 0; result = 0;
        alu_carry = 0; upd_mask = 0; bit_wr = 0; bit_sel = 0; bit_val = 0;
        load = 0; load_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (flags_o !== 16'hF002) begin
            errors++;
            $display("FAIL R1 reset: flags_o=%h expected f002", flags_o);
        end
        idle("R1 idle after reset");

        alu_op(2'b00, 0, 16'h000F, 16'h0001, 6'h3F, "R4 byte add nibble carry");
        alu_op(2'b00, 0, 16'h007F, 16'h0001, 6'h3F, "R5 byte add overflow");
        alu_op(2'b00, 0, 16'h00FF, 16'h0001, 6'h3F, "R3 byte add carry and zero");
        alu_op(2'b01, 1, 16'h8000, 16'h0001, 6'h3F, "R5 word sub overflow");
        alu_op(2'b01, 1, 16'h0000, 16'h0001, 6'h3F, "R3 word sub borrow");
        drive(0, 16'h0, 0, 4'h0, 0, 1, 2'b00, 0, 16'h12FF, 16'h0001, 16'hAB00, 1, 6'h3F,
              "R6 byte zero ignores high bits");
        drive(0, 16'h0, 0, 4'h0, 0, 1, 2'b00, 1, 16'h12FF, 16'h0001, 16'hAB00, 0, 6'h3F,
              "R6 word sign and nonzero");
        alu_op(2'b00, 1, 16'h0F0F, 16'h0101, 6'h3F, "R7 word parity on low byte");
        alu_op(2'b00, 0, 16'h00FF, 16'h0001, 6'h3F, "R3 set carry before logic");
        alu_op(2'b10, 1, 16'h00F3, 16'h000F, 6'h3F, "R9 logic clears carry keeps aux");
        alu_op(2'b11, 0, 16'h0080, 16'h00FF, 6'h3F, "R9 logic class 11");
        alu_op(2'b00, 0, 16'h00FF, 16'h0001, 6'h08, "R8 mask zero flag only");
        alu_op(2'b00, 0, 16'h007F, 16'h0001, 6'h00, "R8 mask empty");
        drive(0, 16'h0, 1, 4'd9, 1, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R11 set interrupt enable");
        drive(0, 16'h0, 1, 4'd10, 1, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R11 set direction");
        drive(0, 16'h0, 1, 4'd8, 1, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R11 set trap");
        drive(0, 16'h0, 1, 4'd8, 0, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R11 clear trap");
        drive(0, 16'h0, 1, 4'd3, 1, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R11 write to bit 3 ignored");
        drive(0, 16'h0, 1, 4'd1, 0, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R2 clear of bit 1 ignored");
        alu_op(2'b01, 1, 16'h1234, 16'h4321, 6'h3F, "R10 arithmetic leaves control flags");
        drive(1, 16'hFFFF, 0, 4'h0, 0, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R12 load all ones");
        drive(1, 16'h0000, 0, 4'h0, 0, 0, 2'b00, 0, 16'h0, 16'h0, 16'h0, 0, 6'h0, "R2 load zero keeps fixed bits");
        drive(1, 16'h0A55, 1, 4'd0, 1, 1, 2'b00, 0, 16'h00FF, 16'h0001, 16'h0000, 1, 6'h3F,
              "R12 load wins over bit write and update");
        drive(0, 16'h0, 1, 4'd6, 0, 1, 2'b00, 0, 16'h00FF, 16'h0001, 16'h0000, 1, 6'h3F,
              "R12 bit write wins over update");
        idle("R8 idle holds value");

        for (int i = 0; i < 300; i++) begin
            logic [15:0] a, b;
            logic [1:0]  cls;
            logic [5:0]  m;
            a   = 16'($urandom());
            b   = 16'($urandom());
            cls = 2'($urandom());
            m   = (i % 3 == 0) ? 6'($urandom()) : 6'h3F;
            alu_op(cls, 1'($urandom()), a, b, m, "R3 R4 R5 R6 R7 R8 random op");
        end
        idle("R10 final idle");

        @(posedge clk);
        #2;
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule